// File: doc/BRIEF.md
# Video Path Self-Test Pattern CRC

This block is a built-in self-test controller for a video processing pipeline. When a run starts it produces a synthetic stream of exactly two frames. Each pixel is a horizontal brightness ramp with a small pseudo-random value added to it. The stream is driven into the pipeline input one pixel per clock, together with start-of-frame and end-of-line markers.

The block watches the processed stream that comes back from the pipeline. It recovers each pixel's column and row from the returned markers. Only the pixels inside a programmable rectangle are folded into a CRC-32 signature. When the last pixel of the second frame has returned, the signature is compared with an expected value.

A mismatch has three effects:
- a sticky failure flag is set, and it holds back the display-mode grant even while display mode is requested;
- an error-log strobe is issued;
- the pass result is cleared.

A run starts in one of two ways:
- automatically in the first idle cycle after reset, if the auto-arm input is high;
- on a start command, which is accepted only while the system is in standby.

Top module: `vst_bist`

## Requirements
- R1: After reset, busy, done, pass, fail_lock, err_log, cmd_rej, display_grant and gen_valid are all 0.
- R2: A run emits exactly 2 frames of H_PIX x V_LIN pixels, one pixel on each clock with gen_valid high and no gaps. gen_sof is high on the first pixel of each frame. gen_eol is high on the last pixel of each line.
- R3: The pixel value is the column index (truncated or zero-extended to PIX_W), plus the low NOISE_W bits of a 16-bit LFSR, modulo 2^PIX_W. The LFSR is reloaded with 16'hACE1 at each run start, and the first pixel uses the seed. After each pixel it shifts left, taking in bit l[15]^l[13]^l[12]^l[10].
- R4: The signature is CRC-32 with polynomial 0x04C11DB7. It starts at 0xFFFFFFFF, processes the data MSB first, and uses no reflection and no final XOR. It is updated once per returned valid pixel whose column lies in win_x0..win_x1 and whose row lies in win_y0..win_y1 (inclusive), in both frames. Column and row are recovered from ret_sof and ret_eol.
- R5: After the last returned pixel of frame 2, done pulses high for one cycle and busy falls. pass is 1 exactly when the signature equals exp_crc.
- R6: On a mismatch, pass is 0 and fail_lock goes to 1. err_log pulses for one cycle in the same cycle as done. fail_lock holds until the next run starts.
- R7: display_grant is registered, one cycle after its inputs, as display_req AND NOT fail_lock AND NOT busy.
- R8: start is accepted only while idle and standby is high. Any other start is ignored and sets cmd_rej. cmd_rej stays set until a run is accepted.
- R9: If auto_arm is high in the first idle cycle after reset, a run starts without regard to standby.
- R10: The window bounds and exp_crc are captured when a run starts. Changing them during the run has no effect on the result.
- R11: Two runs with the same window and the same pipeline give the same result, because the noise restarts from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_arm | input | 1 | Run once automatically after reset |
| standby | input | 1 | System is in standby; commands are allowed |
| start | input | 1 | Start command |
| display_req | input | 1 | Request to enter display mode |
| win_x0 | input | X_W | First column of the CRC window |
| win_x1 | input | X_W | Last column of the CRC window |
| win_y0 | input | Y_W | First row of the CRC window |
| win_y1 | input | Y_W | Last row of the CRC window |
| exp_crc | input | 32 | Expected signature |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run matched |
| fail_lock | output | 1 | Last run failed; display held off |
| err_log | output | 1 | One-cycle error-log strobe |
| cmd_rej | output | 1 | A start was rejected |
| display_grant | output | 1 | Display mode allowed |
| gen_valid | output | 1 | Generated pixel valid |
| gen_sof | output | 1 | Generated start of frame |
| gen_eol | output | 1 | Generated end of line |
| gen_data | output | PIX_W | Generated pixel |
| ret_valid | input | 1 | Returned pixel valid |
| ret_sof | input | 1 | Returned start of frame |
| ret_eol | input | 1 | Returned end of line |
| ret_data | input | PIX_W | Returned processed pixel |

## Verification
The hardest case to reach from the ports is a single wrong pixel somewhere in two full frames. It must be visible only through the final signature, while the window bounds decide which rows and columns count. The bench substitutes an XOR pipeline whose key it can change while idle, and computes the expected signature from its own model of the ramp, the noise and the CRC. A changed key, a shifted window, or mid-run changes to the window and expected value each steer the run to a known pass or fail. The bench also checks every generated pixel against its own noise model, and reuses the same configuration twice to confirm the result repeats.

// File: rtl/vst_pkg.sv
package vst_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} vst_state_t;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;
endpackage

// File: rtl/vst_pattern_gen.sv
module vst_pattern_gen #(
  parameter int H_PIX   = 1920,
  parameter int V_LIN   = 608,
  parameter int PIX_W   = 8,
  parameter int NOISE_W = 4,
  parameter int X_W     = $clog2(H_PIX),
  parameter int Y_W     = $clog2(V_LIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  output logic             o_valid,
  output logic             o_sof,
  output logic             o_eol,
  output logic [PIX_W-1:0] o_data
);
  import vst_pkg::*;

  localparam logic [X_W-1:0] X_LAST = X_W'(H_PIX - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_LIN - 1);

  logic           active;
  logic [X_W-1:0] col;
  logic [Y_W-1:0] row;
  logic           frm;
  logic [15:0]    lfsr;
  logic           fb;
  logic           at_eol, at_eof;

  assign fb     = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  assign at_eol = (col == X_LAST);
  assign at_eof = at_eol && (row == Y_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      col     <= '0;
      row     <= '0;
      frm     <= 1'b0;
      lfsr    <= LFSR_SEED;
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_eol   <= 1'b0;
      o_data  <= '0;
    end else if (init) begin
      active  <= 1'b1;
      col     <= '0;
      row     <= '0;
      frm     <= 1'b0;
      lfsr    <= LFSR_SEED;
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_eol   <= 1'b0;
    end else if (active) begin
      o_valid <= 1'b1;
      o_sof   <= (col == '0) && (row == '0);
      o_eol   <= at_eol;
      o_data  <= PIX_W'(col) + PIX_W'(lfsr[NOISE_W-1:0]);
      lfsr    <= {lfsr[14:0], fb};
      if (at_eol) begin
        col <= '0;
        if (at_eof) begin
          row <= '0;
          frm <= 1'b1;
          if (frm) active <= 1'b0;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end else begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_eol   <= 1'b0;
    end
  end

  a_r2_eol_needs_valid: assert property (@(posedge clk) disable iff (rst)
    o_eol |-> o_valid);
  a_r2_sof_needs_valid: assert property (@(posedge clk) disable iff (rst)
    o_sof |-> o_valid);
endmodule

// File: rtl/vst_crc_win.sv
module vst_crc_win #(
  parameter int H_PIX = 1920,
  parameter int V_LIN = 608,
  parameter int PIX_W = 8,
  parameter int X_W   = $clog2(H_PIX),
  parameter int Y_W   = $clog2(V_LIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic [X_W-1:0]   x0,
  input  logic [X_W-1:0]   x1,
  input  logic [Y_W-1:0]   y0,
  input  logic [Y_W-1:0]   y1,
  input  logic             i_valid,
  input  logic             i_sof,
  input  logic             i_eol,
  input  logic [PIX_W-1:0] i_data,
  output logic [31:0]      crc,
  output logic             fin
);
  import vst_pkg::*;

  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_LIN - 1);

  logic [X_W-1:0] col;
  logic [Y_W-1:0] row;
  logic           frm;
  logic [X_W-1:0] pos_x;
  logic [Y_W-1:0] pos_y;
  logic           in_win;

  function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                           input logic [PIX_W-1:0] d);
    logic [31:0] c;
    logic        f;
    c = c_in;
    for (int i = PIX_W - 1; i >= 0; i--) begin
      f = c[31] ^ d[i];
      c = {c[30:0], 1'b0};
      if (f) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  assign pos_x  = i_sof ? '0 : col;
  assign pos_y  = i_sof ? '0 : row;
  assign in_win = (pos_x >= x0) && (pos_x <= x1) && (pos_y >= y0) && (pos_y <= y1);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      col <= '0;
      row <= '0;
      frm <= 1'b0;
      crc <= CRC_INIT;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (i_valid) begin
        if (in_win) crc <= crc_step(crc, i_data);
        if (i_eol) begin
          col <= '0;
          if (pos_y == Y_LAST) begin
            row <= '0;
            frm <= 1'b1;
            if (frm) fin <= 1'b1;
          end else begin
            row <= pos_y + 1'b1;
          end
        end else begin
          col <= pos_x + 1'b1;
        end
      end
    end
  end

  a_r4_crc_only_in_window: assert property (@(posedge clk) disable iff (rst)
    (!init && !(i_valid && in_win)) |=> $stable(crc));
  a_r5_fin_single: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/vst_bist.sv
module vst_bist #(
  parameter int H_PIX   = 1920,
  parameter int V_LIN   = 608,
  parameter int PIX_W   = 8,
  parameter int NOISE_W = 4,
  parameter int X_W     = $clog2(H_PIX),
  parameter int Y_W     = $clog2(V_LIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_arm,
  input  logic             standby,
  input  logic             start,
  input  logic             display_req,
  input  logic [X_W-1:0]   win_x0,
  input  logic [X_W-1:0]   win_x1,
  input  logic [Y_W-1:0]   win_y0,
  input  logic [Y_W-1:0]   win_y1,
  input  logic [31:0]      exp_crc,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail_lock,
  output logic             err_log,
  output logic             cmd_rej,
  output logic             display_grant,
  output logic             gen_valid,
  output logic             gen_sof,
  output logic             gen_eol,
  output logic [PIX_W-1:0] gen_data,
  input  logic             ret_valid,
  input  logic             ret_sof,
  input  logic             ret_eol,
  input  logic [PIX_W-1:0] ret_data
);
  import vst_pkg::*;

  vst_state_t     st;
  logic           pend;
  logic           init;
  logic           go_auto, go_cmd, go;
  logic [X_W-1:0] x0_q, x1_q;
  logic [Y_W-1:0] y0_q, y1_q;
  logic [31:0]    exp_q;
  logic [31:0]    crc_val;
  logic           crc_fin;
  logic           match;

  assign go_auto = (st == ST_IDLE) && pend && auto_arm;
  assign go_cmd  = (st == ST_IDLE) && start && standby && !go_auto;
  assign go      = go_auto || go_cmd;
  assign match   = (crc_val == exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      pend          <= 1'b1;
      init          <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      pass          <= 1'b0;
      fail_lock     <= 1'b0;
      err_log       <= 1'b0;
      cmd_rej       <= 1'b0;
      display_grant <= 1'b0;
      x0_q          <= '0;
      x1_q          <= '0;
      y0_q          <= '0;
      y1_q          <= '0;
      exp_q         <= '0;
    end else begin
      init          <= 1'b0;
      done          <= 1'b0;
      err_log       <= 1'b0;
      display_grant <= display_req && !fail_lock && !busy;
      if (st == ST_IDLE) pend <= 1'b0;
      if (start && !go_cmd && !go_auto) cmd_rej <= 1'b1;
      case (st)
        ST_IDLE: if (go) begin
          st        <= ST_RUN;
          init      <= 1'b1;
          busy      <= 1'b1;
          pass      <= 1'b0;
          fail_lock <= 1'b0;
          cmd_rej   <= 1'b0;
          x0_q      <= win_x0;
          x1_q      <= win_x1;
          y0_q      <= win_y0;
          y1_q      <= win_y1;
          exp_q     <= exp_crc;
        end
        ST_RUN: if (crc_fin) begin
          st        <= ST_IDLE;
          busy      <= 1'b0;
          done      <= 1'b1;
          pass      <= match;
          fail_lock <= !match;
          err_log   <= !match;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  vst_pattern_gen #(
    .H_PIX(H_PIX), .V_LIN(V_LIN), .PIX_W(PIX_W), .NOISE_W(NOISE_W),
    .X_W(X_W), .Y_W(Y_W)
  ) u_gen (
    .clk(clk), .rst(rst), .init(init),
    .o_valid(gen_valid), .o_sof(gen_sof), .o_eol(gen_eol), .o_data(gen_data)
  );

  vst_crc_win #(
    .H_PIX(H_PIX), .V_LIN(V_LIN), .PIX_W(PIX_W), .X_W(X_W), .Y_W(Y_W)
  ) u_crc (
    .clk(clk), .rst(rst), .init(init),
    .x0(x0_q), .x1(x1_q), .y0(y0_q), .y1(y1_q),
    .i_valid(ret_valid), .i_sof(ret_sof), .i_eol(ret_eol), .i_data(ret_data),
    .crc(crc_val), .fin(crc_fin)
  );

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r6_err_with_lock: assert property (@(posedge clk) disable iff (rst)
    err_log |-> (fail_lock && done));
  a_r7_no_display_on_fail: assert property (@(posedge clk) disable iff (rst)
    fail_lock |=> !display_grant);
  a_r8_reject_outside_standby: assert property (@(posedge clk) disable iff (rst)
    (start && !standby && !go_auto) |=> cmd_rej);
endmodule

// File: tb/vst_bist_tb.sv
module vst_bist_tb;
  localparam int H = 32;
  localparam int V = 8;
  localparam int PW = 8;
  localparam int NW = 4;
  localparam int XW = $clog2(H);
  localparam int YW = $clog2(V);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, auto_arm, standby, start, display_req;
  logic [XW-1:0] win_x0, win_x1;
  logic [YW-1:0] win_y0, win_y1;
  logic [31:0] exp_crc;
  logic busy, done, pass, fail_lock, err_log, cmd_rej, display_grant;
  logic gen_valid, gen_sof, gen_eol;
  logic [PW-1:0] gen_data;
  logic ret_valid = 1'b0, ret_sof = 1'b0, ret_eol = 1'b0;
  logic [PW-1:0] ret_data = '0;
  logic [PW-1:0] key = 8'h5A;

  int n_run = 0, n_fail = 0;

  vst_bist #(.H_PIX(H), .V_LIN(V), .PIX_W(PW), .NOISE_W(NW)) u_dut (
    .clk(clk), .rst(rst), .auto_arm(auto_arm), .standby(standby), .start(start),
    .display_req(display_req), .win_x0(win_x0), .win_x1(win_x1),
    .win_y0(win_y0), .win_y1(win_y1), .exp_crc(exp_crc),
    .busy(busy), .done(done), .pass(pass), .fail_lock(fail_lock),
    .err_log(err_log), .cmd_rej(cmd_rej), .display_grant(display_grant),
    .gen_valid(gen_valid), .gen_sof(gen_sof), .gen_eol(gen_eol), .gen_data(gen_data),
    .ret_valid(ret_valid), .ret_sof(ret_sof), .ret_eol(ret_eol), .ret_data(ret_data)
  );

  // substitute pipeline: one register stage, XOR with a key
  always_ff @(posedge clk) begin
    ret_valid <= gen_valid;
    ret_sof   <= gen_sof;
    ret_eol   <= gen_eol;
    ret_data  <= gen_data ^ key;
  end

  function automatic logic [15:0] lf_next(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  // monitor of the generated stream (R2, R3)
  int mon_pix, mon_sof, mon_eol, mon_bad;
  logic [15:0] mon_lfsr;
  always @(negedge clk) begin
    if (gen_valid) begin
      int cx;
      logic [PW-1:0] ev;
      cx = mon_pix % H;
      ev = PW'(cx) + PW'(mon_lfsr[NW-1:0]);
      if (gen_data !== ev) mon_bad++;
      if (gen_sof !== (mon_pix % (H*V) == 0)) mon_bad++;
      if (gen_eol !== (cx == H-1)) mon_bad++;
      if (gen_sof) mon_sof++;
      if (gen_eol) mon_eol++;
      mon_lfsr = lf_next(mon_lfsr);
      mon_pix++;
    end
  end

  task automatic mon_clear();
    mon_pix = 0; mon_sof = 0; mon_eol = 0; mon_bad = 0; mon_lfsr = 16'hACE1;
  endtask

  function automatic logic [31:0] model_crc(input int x0, input int x1, input int y0,
                                            input int y1, input logic [PW-1:0] k);
    logic [31:0] c;
    logic [15:0] l;
    logic [PW-1:0] p;
    logic f;
    c = 32'hFFFFFFFF;
    l = 16'hACE1;
    for (int fr = 0; fr < 2; fr++)
      for (int y = 0; y < V; y++)
        for (int x = 0; x < H; x++) begin
          p = (PW'(x) + PW'(l[NW-1:0])) ^ k;
          l = lf_next(l);
          if (x >= x0 && x <= x1 && y >= y0 && y <= y1)
            for (int b = PW-1; b >= 0; b--) begin
              f = c[31] ^ p[b];
              c = {c[30:0], 1'b0};
              if (f) c = c ^ 32'h04C11DB7;
            end
        end
    return c;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  logic seen_done, seen_err, seen_pass;
  task automatic wait_done(input string req);
    seen_done = 1'b0; seen_err = 1'b0; seen_pass = 1'b0;
    for (int i = 0; i < 4000 && !seen_done; i++) begin
      @(negedge clk);
      if (done) begin
        seen_done = 1'b1; seen_err = err_log; seen_pass = pass;
      end
    end
    check(req, "done seen", {31'd0, seen_done}, 32'd1);
  endtask

  task automatic set_win(input int x0, input int x1, input int y0, input int y1,
                         input logic [31:0] e);
    win_x0 = XW'(x0); win_x1 = XW'(x1); win_y0 = YW'(y0); win_y1 = YW'(y1);
    exp_crc = e;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_reset(input logic arm);
    auto_arm = arm;
    @(negedge clk); rst = 1'b1;
    mon_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "busy", {31'd0, busy}, 0);
    check("R1", "done", {31'd0, done}, 0);
    check("R1", "pass", {31'd0, pass}, 0);
    check("R1", "fail_lock", {31'd0, fail_lock}, 0);
    check("R1", "err_log", {31'd0, err_log}, 0);
    check("R1", "cmd_rej", {31'd0, cmd_rej}, 0);
    check("R1", "display_grant", {31'd0, display_grant}, 0);
    check("R1", "gen_valid", {31'd0, gen_valid}, 0);
  endtask

  task automatic t_pass_full();
    set_win(0, H-1, 0, V-1, model_crc(0, H-1, 0, V-1, key));
    standby = 1'b1; display_req = 1'b1;
    mon_clear();
    pulse_start();
    check("R8", "busy after accepted start", {31'd0, busy}, 1);
    wait_done("R5");
    check("R5", "pass full window", {31'd0, seen_pass}, 1);
    check("R6", "no err_log on pass", {31'd0, seen_err}, 0);
    check("R2", "pixel count", mon_pix, 2*H*V);
    check("R2", "sof count", mon_sof, 2);
    check("R2", "eol count", mon_eol, 2*V);
    check("R3", "pixel value mismatches", mon_bad, 0);
    repeat (2) @(negedge clk);
    check("R7", "grant after pass", {31'd0, display_grant}, 1);
  endtask

  task automatic t_window_sub();
    set_win(3, 20, 2, 5, model_crc(3, 20, 2, 5, key));
    pulse_start();
    wait_done("R4");
    check("R4", "pass sub window", {31'd0, seen_pass}, 1);
    set_win(3, 20, 2, 5, model_crc(3, 21, 2, 5, key));
    pulse_start();
    wait_done("R4");
    check("R4", "window edge column counted wrongly", {31'd0, seen_pass}, 0);
  endtask

  task automatic t_fail();
    set_win(0, H-1, 0, V-1, model_crc(0, H-1, 0, V-1, key));
    key = 8'h5B;
    display_req = 1'b1;
    pulse_start();
    wait_done("R6");
    check("R6", "pass on corrupt pipeline", {31'd0, seen_pass}, 0);
    check("R6", "err_log with done", {31'd0, seen_err}, 1);
    check("R6", "fail_lock", {31'd0, fail_lock}, 1);
    @(negedge clk);
    check("R6", "err_log single pulse", {31'd0, err_log}, 0);
    repeat (2) @(negedge clk);
    check("R7", "grant blocked by fail_lock", {31'd0, display_grant}, 0);
    key = 8'h5A;
    pulse_start();
    @(negedge clk);
    check("R6", "fail_lock cleared on new run", {31'd0, fail_lock}, 0);
    check("R7", "grant low while busy", {31'd0, display_grant}, 0);
    wait_done("R6");
    check("R6", "pass after recovery", {31'd0, seen_pass}, 1);
  endtask

  task automatic t_reject();
    standby = 1'b0;
    pulse_start();
    repeat (3) @(negedge clk);
    check("R8", "busy after rejected start", {31'd0, busy}, 0);
    check("R8", "cmd_rej set", {31'd0, cmd_rej}, 1);
    check("R8", "gen idle after reject", {31'd0, gen_valid}, 0);
    standby = 1'b1;
    pulse_start();
    check("R8", "cmd_rej cleared by accepted start", {31'd0, cmd_rej}, 0);
    wait_done("R8");
  endtask

  task automatic t_sample();
    logic [31:0] e;
    e = model_crc(1, 10, 0, 3, key);
    set_win(1, 10, 0, 3, e);
    pulse_start();
    repeat (5) @(negedge clk);
    set_win(0, 0, 7, 7, ~e);
    wait_done("R10");
    check("R10", "mid-run config change ignored", {31'd0, seen_pass}, 1);
    set_win(1, 10, 0, 3, e);
    pulse_start();
    wait_done("R11");
    check("R11", "repeat run same result", {31'd0, seen_pass}, 1);
  endtask

  task automatic t_auto();
    standby = 1'b0;
    set_win(0, H-1, 0, V-1, model_crc(0, H-1, 0, V-1, key));
    do_reset(1'b1);
    wait_done("R9");
    check("R9", "auto run passes without standby", {31'd0, seen_pass}, 1);
    check("R9", "cmd_rej not set by auto run", {31'd0, cmd_rej}, 0);
  endtask

  initial begin
    rst = 1'b1; auto_arm = 1'b0; standby = 1'b0; start = 1'b0; display_req = 1'b0;
    set_win(0, 0, 0, 0, 32'd0);
    do_reset(1'b0);
    repeat (2) @(negedge clk);
    t_reset();
    t_pass_full();
    t_window_sub();
    t_fail();
    t_reject();
    t_sample();
    t_auto();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule